// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

This block arbitrates thirteen interrupt sources for a small processor core. Each source owns a pending flag, an individual enable and a two-bit priority. A global enable gates every request. Among the sources that are pending and enabled, the block picks the one with the highest priority level. When several requests share that level, it picks the lowest source index. It presents the winner's index and a request line to the core.

The block keeps one in-service bit for each of the four levels. A request reaches the core only when its level is strictly above every level now in service, so handlers nest by priority. The core answers with an acknowledge strobe: the block latches the vector, marks the level as in service and, for edge-type sources, clears the pending flag. A return strobe retires the innermost handler. A separate wake output flags a pending, enabled request from any source in a parameterised wake set, whatever the global enable.

Top module: `irq_prio_ctrl`

## Requirements
- R1: An edge-type source (bit set in EDGE_MASK; default: every source except 2 and 3) sets its pending flag when its `src_i` bit is high at a clock edge. The flag stays set until the source is acknowledged, and is then cleared.
- R2: A level-type source is pending exactly while its `src_i` bit is high. Acknowledge leaves it pending.
- R3: A source can raise `irq_o` only while both its `en_i` bit and `gen_i` are 1.
- R4: Source i has its priority in `prio_i[2i+1:2i]`. Level 3 is the highest, and a higher level wins over a lower level whatever the indices.
- R5: Among requests at the winning level, the lowest source index is presented on `irq_idx_o`.
- R6: `irq_o` is 1 only if the winning level is strictly above every set bit of `in_svc_o`. Bit L of `in_svc_o` is level L.
- R7: An acknowledge while `irq_o` is 1 latches `irq_idx_o` into `svc_idx_o` and sets the winner's level bit in `in_svc_o` at the same edge. An acknowledge while `irq_o` is 0 has no effect.
- R8: A return strobe clears only the highest set bit of `in_svc_o`.
- R9: `wake_o` is 1 while any source is pending, has its `en_i` bit set and is in WAKE_MASK (default 13'h1C3F). `gen_i` does not affect it.
- R10: After reset, `irq_o`, `wake_o`, `in_svc_o` and `svc_idx_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 13 | Raw source requests |
| en_i | input | 13 | Per-source enables |
| gen_i | input | 1 | Global enable |
| prio_i | input | 26 | Two-bit priority per source |
| ack_i | input | 1 | Acknowledge strobe from the core |
| ret_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Request to the core |
| irq_idx_o | output | 4 | Index of the winning source |
| svc_idx_o | output | 4 | Vector latched at the last acknowledge |
| in_svc_o | output | 4 | In-service bit per level |
| wake_o | output | 1 | Power-down wake request |

## Verification
Arbitration is combinational from pending state and inputs. A level-type source, an enable or a priority change therefore shows on `irq_o` and `irq_idx_o` in the same cycle. An edge strobe shows one edge later, once the pending flag is registered. Acknowledge and return act on `svc_idx_o`, `in_svc_o`, the pending flags and `wake_o` at the edge where they are sampled. The bench drives every input 1 ns after a rising edge and checks outputs before the next edge. Registered results are therefore read exactly one edge after their strobe, and combinational ones in the same cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned PRIO_W = 2;
  localparam int unsigned LVL_N  = 1 << PRIO_W;
  typedef logic [PRIO_W-1:0] lvl_t;
  typedef logic [LVL_N-1:0]  lvl_vec_t;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned     N_SRC     = 13,
  parameter logic [N_SRC-1:0] EDGE_MASK = 13'h1FF3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      logic flag_q;
      // a new strobe in the acknowledge cycle wins over the clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= src_i[i] | (flag_q & ~clr_i[i]);
      end
      assign pend_o[i] = flag_q;

      // R1
      edge_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[i] && !src_i[i]) |=> !pend_o[i]);
    end else begin : g_level
      assign pend_o[i] = src_i[i];
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 13,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        req_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  lvl_vec_t                isr_i,
  output logic                    irq_o,
  output logic [IDX_W-1:0]        idx_o,
  output lvl_t                    lvl_o
);
  logic     found;
  lvl_vec_t ge_mask;

  // strict compare keeps the earlier (lower) index on a tie
  always_comb begin
    found = 1'b0;
    lvl_o = '0;
    idx_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] > lvl_o)) begin
        found = 1'b1;
        lvl_o = prio_i[i*PRIO_W +: PRIO_W];
        idx_o = IDX_W'(i);
      end
    end
  end

  assign ge_mask = {LVL_N{1'b1}} << lvl_o;
  assign irq_o   = found && !(|(isr_i & ge_mask));
endmodule

// File: rtl/irq_isr.sv
module irq_isr
  import irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     set_i,
  input  lvl_t     lvl_i,
  input  logic     ret_i,
  output lvl_vec_t isr_o
);
  lvl_vec_t isr_q, top_bit, set_bit;

  always_comb begin
    top_bit = '0;
    for (int l = 0; l < LVL_N; l++) begin
      if (isr_q[l]) begin
        top_bit    = '0;
        top_bit[l] = 1'b1;
      end
    end
  end

  assign set_bit = set_i ? (LVL_N'(1) << lvl_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~(ret_i ? top_bit : '0)) | set_bit;
  end

  assign isr_o = isr_q;

  // R7
  isr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> isr_q[$past(lvl_i)]);

  // R8
  isr_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !set_i && isr_q != '0) |=> $countones(isr_q) == $past($countones(isr_q)) - 1);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned      N_SRC     = 13,
  parameter logic [N_SRC-1:0] EDGE_MASK = 13'h1FF3,
  parameter logic [N_SRC-1:0] WAKE_MASK = 13'h1C3F,
  localparam int unsigned     IDX_W     = $clog2(N_SRC)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        src_i,
  input  logic [N_SRC-1:0]        en_i,
  input  logic                    gen_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic                    ack_i,
  input  logic                    ret_i,
  output logic                    irq_o,
  output logic [IDX_W-1:0]        irq_idx_o,
  output logic [IDX_W-1:0]        svc_idx_o,
  output logic [LVL_N-1:0]        in_svc_o,
  output logic                    wake_o
);
  logic [N_SRC-1:0] pend, req, clr;
  logic             ack_ok;
  lvl_t             win_lvl;
  logic [IDX_W-1:0] svc_q;

  assign ack_ok = ack_i & irq_o;
  assign clr    = ack_ok ? (N_SRC'(1) << irq_idx_o) : '0;
  assign req    = pend & en_i & {N_SRC{gen_i}};
  assign wake_o = |(pend & en_i & WAKE_MASK);

  irq_pend #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_pend (
    .clk_i, .rst_ni, .src_i, .clr_i(clr), .pend_o(pend)
  );

  irq_arb #(.N_SRC(N_SRC)) u_arb (
    .req_i(req), .prio_i, .isr_i(in_svc_o),
    .irq_o, .idx_o(irq_idx_o), .lvl_o(win_lvl)
  );

  irq_isr u_isr (
    .clk_i, .rst_ni, .set_i(ack_ok), .lvl_i(win_lvl), .ret_i, .isr_o(in_svc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     svc_q <= '0;
    else if (ack_ok) svc_q <= irq_idx_o;
  end
  assign svc_idx_o = svc_q;

  // R3
  gen_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gen_i && en_i[irq_idx_o]);

  // R6
  preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (in_svc_o >> prio_i[irq_idx_o*PRIO_W +: PRIO_W]) == '0);

  // R7
  vec_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_ok |=> svc_idx_o == $past(irq_idx_o));

  // R7
  ack_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !ret_i) |=> $stable(in_svc_o) && $stable(svc_idx_o));

  // R9
  wake_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !wake_o);
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned N = 13;
  localparam logic [N-1:0] EDGE_M = 13'h1FF3;
  localparam logic [N-1:0] WAKE_M = 13'h1C3F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0, en = '1;
  logic gen = 1'b1, ack = 1'b0, ret = 1'b0;
  logic [2*N-1:0] prio = '0;
  logic irq, wake;
  logic [3:0] irq_idx, svc_idx, in_svc;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl #(.N_SRC(N), .EDGE_MASK(EDGE_M), .WAKE_MASK(WAKE_M)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .en_i(en), .gen_i(gen),
    .prio_i(prio), .ack_i(ack), .ret_i(ret), .irq_o(irq), .irq_idx_o(irq_idx),
    .svc_idx_o(svc_idx), .in_svc_o(in_svc), .wake_o(wake)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(logic [N-1:0] m);
    src = src | m;
    tick();
    src = src & ~m;
    #1;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0; #1;
  endtask

  task automatic do_ret();
    ret = 1'b1; tick(); ret = 1'b0; #1;
  endtask

  task automatic set_prio(int i, logic [1:0] l);
    prio[2*i +: 2] = l;
    #1;
  endtask

  task automatic drain();
    for (int k = 0; k < 16; k++) begin
      if (irq) begin do_ack(); do_ret(); end
    end
    prio = '0;
    #1;
  endtask

  task automatic t_reset();
    chk("R10 irq", irq, 0);
    chk("R10 wake", wake, 0);
    chk("R10 in_svc", in_svc, 0);
    chk("R10 svc_idx", svc_idx, 0);
  endtask

  task automatic t_global();
    gen = 1'b0;
    strobe(13'h0020);
    chk("R3 gen off", irq, 0);
    chk("R9 wake w/o gen", wake, 1);
    gen = 1'b1; #1;
    chk("R3 gen on", irq, 1);
    chk("R3 idx", irq_idx, 5);
    tick(); tick();
    chk("R1 held", irq, 1);
    do_ack();
    chk("R7 svc_idx", svc_idx, 5);
    chk("R7 in_svc", in_svc, 4'b0001);
    chk("R1 cleared wake", wake, 0);
    do_ret();
    chk("R8 ret", in_svc, 0);
    chk("R1 cleared irq", irq, 0);
  endtask

  task automatic t_enable();
    en[6] = 1'b0;
    strobe(13'h0040);
    chk("R3 en off", irq, 0);
    chk("R9 en off wake", wake, 0);
    en[6] = 1'b1; #1;
    chk("R3 en on", irq, 1);
    chk("R3 en idx", irq_idx, 6);
    chk("R9 not in mask", wake, 0);
    drain();
  endtask

  task automatic t_tie();
    set_prio(4, 2'd1);
    set_prio(7, 2'd1);
    strobe(13'h0090);
    chk("R5 tie idx", irq_idx, 4);
    do_ack();
    chk("R7 lvl1", in_svc, 4'b0010);
    do_ret();
    chk("R5 next idx", irq_idx, 7);
    drain();
  endtask

  task automatic t_nest();
    set_prio(9, 2'd3);
    strobe(13'h0202);
    chk("R4 level wins", irq_idx, 9);
    do_ack();
    chk("R7 lvl3", in_svc, 4'b1000);
    chk("R7 svc 9", svc_idx, 9);
    chk("R6 lower blocked", irq, 0);
    do_ret();
    chk("R6 unblocked", irq, 1);
    chk("R6 idx1", irq_idx, 1);
    do_ack();
    chk("R7 lvl0", in_svc, 4'b0001);
    strobe(13'h0040);
    chk("R6 equal blocked", irq, 0);
    set_prio(6, 2'd2);
    chk("R6 higher preempts", irq, 1);
    chk("R6 idx6", irq_idx, 6);
    do_ack();
    chk("R7 nested", in_svc, 4'b0101);
    do_ret();
    chk("R8 top only", in_svc, 4'b0001);
    do_ret();
    chk("R8 empty", in_svc, 0);
    drain();
  endtask

  task automatic t_level_src();
    src[2] = 1'b1; #1;
    chk("R2 same cycle", irq, 1);
    chk("R2 idx", irq_idx, 2);
    do_ack();
    chk("R2 blocked in svc", irq, 0);
    do_ret();
    chk("R2 still pending", irq, 1);
    src[2] = 1'b0; #1;
    chk("R2 follows input", irq, 0);
    do_ack();
    chk("R7 ack ignored", in_svc, 0);
    chk("R7 svc unchanged", svc_idx, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_global();
    t_enable();
    t_tie();
    t_nest();
    t_level_src();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule